// File: doc/BRIEF.md
# Serial Shift-and-Add Multiply-Accumulate Unit

This block multiplies two WIDTH-bit operands and adds a WIDTH-bit addend. It returns the 2·WIDTH-bit value mcand·mplier + addend. It spends one clock cycle on each multiplier bit, starting with the least significant. The accumulator is one 2·WIDTH-bit shift register. Its upper half collects partial products through a single WIDTH-bit adder (with one extra sign/carry bit). Its lower half starts out holding the multiplier, which shifts out as the product bits shift in. The addend is preloaded into the upper half, so after WIDTH right shifts it ends up at unit weight. No separate final addition is needed.

A single input selects the mode. In unsigned mode every operand is a plain binary number. In two's-complement mode the accumulator shifts arithmetically, so partial products keep their sign. The most significant multiplier bit carries negative weight, so its partial product is subtracted: the unit adds the inverted multiplicand with a carry-in of one. A host pulses `start` with the operands, waits while `busy` is high, and reads `result` once `done` is high.

Top module: `seq_mac`

## Requirements
- R1: With signed_mode=0, result equals mcand·mplier + addend, with every operand taken as unsigned, once done is high.
- R2: With signed_mode=1, result equals mcand·mplier + addend, with every operand taken as two's complement. The result is the 2·WIDTH-bit two's-complement value, including cases where the multiplier's top bit is 1.
- R3: Consider the rising edge that accepts start. busy is high for exactly WIDTH clock cycles after that edge. On the next edge busy falls and done rises, and the two are never high together.
- R4: A start pulse seen while busy is high is ignored. It changes neither the operation in progress, its result, nor its completion time.
- R5: Once done is high, result and done stay unchanged until the next accepted start, whatever the operand inputs do.
- R6: While rst is high (synchronous, active high), busy, done and result all become 0 on the next edge. This also aborts an operation in progress.
- R7: Extreme operands give exact results without wraparound. Unsigned 255·255+255 gives 0xFF00. Signed (−128)·(−128)+127 gives 0x407F (for WIDTH=8).
- R8: When start is accepted, done falls and busy rises on that same edge.
- R9: The addend is zero-extended in unsigned mode and sign-extended in signed mode. With both factors 0 and addend 0x80 (WIDTH=8), result is 0x0080 unsigned and 0xFF80 signed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation; sampled only while not busy |
| signed_mode | input | 1 | 1 = two's complement, 0 = unsigned; latched with start |
| mcand | input | WIDTH | Multiplicand, latched with start |
| mplier | input | WIDTH | Multiplier, latched with start |
| addend | input | WIDTH | Addend, latched with start |
| busy | output | 1 | High while iterations run |
| done | output | 1 | High from completion until the next accepted start |
| result | output | 2·WIDTH | Accumulator; final product-plus-addend when done |

## Verification
The embedded properties take it for granted that rst is held high from time zero until at least one clock edge has passed, so the control registers have a defined value before any property is evaluated. They also take for granted that every input is stable around the rising edge. The bench meets both conditions: it starts in reset and changes every input only on falling edges. The result-hold property covers only cycles with no start pulse, so that it does not conflict with an accepted start. The stimulus deliberately pulses start during busy and changes the operands after done to exercise those windows.

// File: rtl/seq_mac_pkg.sv
package seq_mac_pkg;

  // Extension bit for a value entering the (WIDTH+1)-bit adder.
  function automatic logic ext_bit(input logic is_signed, input logic msb);
    return is_signed & msb;
  endfunction

endpackage

// File: rtl/seq_mac_ctrl.sv
module seq_mac_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic step,
  output logic last,
  output logic busy,
  output logic done
);
  localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WIDTH - 1);

  logic [CNT_W-1:0] iter_q;

  assign load = start & ~busy;
  assign step = busy;
  assign last = busy & (iter_q == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      iter_q <= '0;
    end else if (load) begin
      busy   <= 1'b1;
      done   <= 1'b0;
      iter_q <= '0;
    end else if (busy) begin
      if (last) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        iter_q <= iter_q + 1'b1;
      end
    end
  end

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst) !(busy && done)); // R3
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (rst) last |=> (!busy && done)); // R3
  AST_ITER_RANGE: assert property (@(posedge clk) disable iff (rst) busy |-> (iter_q <= CNT_LAST)); // R3
  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> (busy && !done)); // R8

endmodule

// File: rtl/seq_mac_pp_sel.sv
module seq_mac_pp_sel #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] mcand,
  input  logic             mbit,
  input  logic             negate,
  output logic [WIDTH-1:0] pp,
  output logic             cin
);
  // Per-bit gate: multiplier bit selects multiplicand, negate inverts it.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign pp[i] = mbit & (mcand[i] ^ negate);
  end
  assign cin = mbit & negate;
endmodule

// File: rtl/seq_mac_addshift.sv
module seq_mac_addshift #(
  parameter int WIDTH = 8
) (
  input  logic             is_signed,
  input  logic [WIDTH-1:0] hi,
  input  logic [WIDTH-1:0] pp,
  input  logic             cin,
  output logic [WIDTH-1:0] hi_next,
  output logic             lsb_out
);
  import seq_mac_pkg::*;

  logic [WIDTH:0] sum;

  always_comb begin
    sum = {ext_bit(is_signed, hi[WIDTH-1]), hi}
        + {ext_bit(is_signed, pp[WIDTH-1]), pp}
        + {{WIDTH{1'b0}}, cin};
    hi_next = sum[WIDTH:1];
    lsb_out = sum[0];
  end
endmodule

// File: rtl/seq_mac.sv
module seq_mac #(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               signed_mode,
  input  logic [WIDTH-1:0]   mcand,
  input  logic [WIDTH-1:0]   mplier,
  input  logic [WIDTH-1:0]   addend,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] result
);
  localparam int RES_W = 2 * WIDTH;

  logic             load, step, last;
  logic [WIDTH-1:0] mcand_q, acc_hi, acc_lo, pp, hi_next;
  logic             sgn_q, cin, lsb_out;

  seq_mac_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .load(load), .step(step), .last(last), .busy(busy), .done(done)
  );

  seq_mac_pp_sel #(.WIDTH(WIDTH)) u_pp (
    .mcand(mcand_q), .mbit(acc_lo[0]), .negate(sgn_q & last),
    .pp(pp), .cin(cin)
  );

  seq_mac_addshift #(.WIDTH(WIDTH)) u_add (
    .is_signed(sgn_q), .hi(acc_hi), .pp(pp), .cin(cin),
    .hi_next(hi_next), .lsb_out(lsb_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand_q <= '0;
      sgn_q   <= 1'b0;
      acc_hi  <= '0;
      acc_lo  <= '0;
    end else if (load) begin
      mcand_q <= mcand;
      sgn_q   <= signed_mode;
      acc_hi  <= addend;
      acc_lo  <= mplier;
    end else if (step) begin
      acc_hi  <= hi_next;
      acc_lo  <= {lsb_out, acc_lo[WIDTH-1:1]};
    end
  end

  assign result = RES_W'({acc_hi, acc_lo});

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst) (done && !start) |=> (done && $stable(result))); // R5
  AST_IGNORE_START: assert property (@(posedge clk) disable iff (rst) (busy && start) |=> ($stable(mcand_q) && $stable(sgn_q))); // R4

endmodule

// File: tb/seq_mac_bench.sv
`timescale 1ns/1ps
module seq_mac_bench;
  localparam int W  = 8;
  localparam int RW = 2 * W;
  localparam int NV = 12;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, sgn = 1'b0;
  logic [W-1:0] a = '0, x = '0, y = '0;
  logic busy, done;
  logic [RW-1:0] result;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  seq_mac #(.WIDTH(W)) u_seq_mac (
    .clk(clk), .rst(rst), .start(start), .signed_mode(sgn),
    .mcand(a), .mplier(x), .addend(y),
    .busy(busy), .done(done), .result(result)
  );

  // {signed, mcand, mplier, addend, expected}
  localparam logic [40:0] VEC [NV] = '{
    {1'b0, 8'h00, 8'h00, 8'h00, 16'h0000},
    {1'b0, 8'hFF, 8'hFF, 8'hFF, 16'hFF00},
    {1'b0, 8'h01, 8'h01, 8'h00, 16'h0001},
    {1'b0, 8'h0C, 8'h0A, 8'h05, 16'h007D},
    {1'b0, 8'h80, 8'h02, 8'h00, 16'h0100},
    {1'b0, 8'h00, 8'hC8, 8'hC8, 16'h00C8},
    {1'b1, 8'h80, 8'h80, 8'h00, 16'h4000},
    {1'b1, 8'hFF, 8'hFF, 8'h00, 16'h0001},
    {1'b1, 8'h7F, 8'h80, 8'h00, 16'hC080},
    {1'b1, 8'h03, 8'hFB, 8'hFF, 16'hFFF0},
    {1'b1, 8'h80, 8'h7F, 8'h80, 16'hC000},
    {1'b1, 8'h00, 8'hFF, 8'h80, 16'hFF80}
  };

  task automatic check(input string req, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [RW-1:0] ref_mac(input logic s, input logic [W-1:0] ra, rx, ry);
    longint va, vx, vy, p;
    logic [RW-1:0] r;
    va = s ? longint'($signed(ra)) : longint'(ra);
    vx = s ? longint'($signed(rx)) : longint'(rx);
    vy = s ? longint'($signed(ry)) : longint'(ry);
    p = va * vx + vy;
    r = p[RW-1:0];
    return r;
  endfunction

  task automatic launch(input logic s, input logic [W-1:0] ia, ix, iy);
    @(negedge clk);
    sgn = s; a = ia; x = ix; y = iy; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    while (busy && lat < 4 * W) begin
      lat++;
      @(negedge clk);
    end
  endtask

  task automatic do_op(input logic s, input logic [W-1:0] ia, ix, iy,
                       input logic [RW-1:0] exp, input string req);
    int lat;
    launch(s, ia, ix, iy);
    wait_done(lat);
    check(req, result, exp);
    check("R3 latency", RW'(lat), RW'(W));
    check("R3 done", RW'(done), RW'(1));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int lat;
    logic [RW-1:0] held;
    repeat (3) @(negedge clk);
    check("R6 reset busy", RW'(busy), '0);
    check("R6 reset done", RW'(done), '0);
    check("R6 reset result", result, '0);
    rst = 1'b0;

    // table of vectors, R1 for unsigned rows, R2 for signed rows
    for (int i = 0; i < NV; i++) begin
      do_op(VEC[i][40], VEC[i][39:32], VEC[i][31:24], VEC[i][23:16], VEC[i][15:0],
            VEC[i][40] ? "R2 table" : "R1 table");
    end

    // strided sweep against the reference model
    for (int ia = 0; ia < 256; ia += 17) begin
      for (int ix = 0; ix < 256; ix += 23) begin
        for (int s = 0; s < 2; s++) begin
          logic [W-1:0] iy;
          iy = W'(ia * 7 + ix * 3);
          do_op(s[0], W'(ia), W'(ix), iy, ref_mac(s[0], W'(ia), W'(ix), iy),
                s ? "R2 sweep" : "R1 sweep");
        end
      end
    end

    // R7 extremes
    do_op(1'b0, 8'hFF, 8'hFF, 8'hFF, 16'hFF00, "R7 unsigned max");
    do_op(1'b1, 8'h80, 8'h80, 8'h7F, 16'h407F, "R7 signed min");

    // R9 addend extension
    do_op(1'b0, 8'h00, 8'h00, 8'h80, 16'h0080, "R9 zero-extend");
    do_op(1'b1, 8'h00, 8'h00, 8'h80, 16'hFF80, "R9 sign-extend");

    // R5 hold after done while inputs change without start
    held = result;
    @(negedge clk);
    sgn = 1'b0; a = 8'h55; x = 8'hAA; y = 8'h11;
    repeat (5) @(negedge clk);
    check("R5 result hold", result, held);
    check("R5 done hold", RW'(done), RW'(1));

    // R8 start clears done
    launch(1'b0, 8'd20, 8'd30, 8'd7);
    check("R8 done cleared", RW'(done), '0);
    check("R8 busy set", RW'(busy), RW'(1));
    // R4 start pulse during busy is ignored
    @(negedge clk);
    a = 8'd99; x = 8'd3; y = 8'd1; sgn = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(lat);
    check("R4 ignored start result", result, 16'h025F);
    check("R4 completion time", RW'(lat), RW'(W - 2));
    check("R4 done", RW'(done), RW'(1));

    // R6 reset aborts an operation
    launch(1'b0, 8'hFF, 8'hFF, 8'hFF);
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R6 abort busy", RW'(busy), '0);
    check("R6 abort done", RW'(done), '0);
    check("R6 abort result", result, '0);
    rst = 1'b0;
    do_op(1'b1, 8'h7F, 8'h7F, 8'h01, 16'h3F02, "R2 after reset");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule